// File: doc/BRIEF.md
# Double-Buffered DMA Channel Pair

This block holds the programmable state of one peripheral's receive and transmit DMA channels. Each direction has a current buffer, made of an address pointer and a remaining-transfer counter, and a queued next buffer with its own pointer and counter. Software programs these registers through a small register bus. An external transfer sequencer moves the data. It reports each completed transfer with a one-cycle done pulse and a 2-bit size code.

On each accepted done pulse, the channel advances its pointer by the transfer size and counts down. When the last transfer of the current buffer completes, the channel raises its end flag. If a next buffer is queued, the channel also moves the next buffer into the current registers in hardware and clears the next counter, so the peripheral keeps streaming without CPU help. Each direction drives a trigger-enable output toward the sequencer. It also drives a flag that stays high while both of its buffers are exhausted: buffer-full for receive and buffer-empty for transmit.

Top module: `dma_chan_pair`

## Requirements
- R1: After reset, every pointer, counter, next pointer and next counter reads 0, both enables are off, both end flags are low, and both full/empty flags are high.
- R2: The register map uses these byte offsets:
  - 0x100 receive pointer, 0x104 receive counter, 0x108 transmit pointer, 0x10C transmit counter.
  - 0x110 receive next pointer, 0x114 receive next counter, 0x118 transmit next pointer, 0x11C transmit next counter.
  - 0x120 control (write only, reads 0) and 0x124 status (read only, writes ignored).
  - Counters keep only the low 16 bits of a write. Unmapped offsets read 0. Read data is 0 unless the bus is in a selected, strobed read.
- R3: A done pulse on a channel whose counter is nonzero decrements the counter by 1. It also adds to the pointer 1 for size code 2'b00, 2 for 2'b01, and 4 for 2'b10 or 2'b11.
- R4: A trigger-enable output is high exactly when that direction is enabled, its counter is nonzero and its ready input is high.
- R5: When a done pulse takes the counter from 1 to 0 while the next counter is 0, the counter stays at 0 and the end flag sets.
- R6: When a done pulse ends a buffer while the next counter is nonzero, the end flag sets, the pointer and counter take the next pointer and next counter, and the next counter becomes 0.
- R7: A write to a channel's counter or next counter clears that channel's end flag.
- R8: Control bit 0 enables receive, bit 1 disables receive, bit 8 enables transmit and bit 9 disables transmit. A zero bit has no effect. A disable bit wins over an enable bit in the same write.
- R9: Status bit 0 shows the receive enable and status bit 8 shows the transmit enable. All other status bits read 0.
- R10: A register write in the same cycle as a done pulse wins for the written register. The channel's other registers still follow the done pulse.
- R11: The receive full flag and the transmit empty flag are high exactly while both the current and next counters of that direction are 0.
- R12: A done pulse on a channel whose counter is 0 changes no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register bus select |
| reg_stb | input | 1 | Register bus strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data |
| rx_ready | input | 1 | Peripheral has a received item |
| tx_ready | input | 1 | Peripheral can take an item |
| rx_done | input | 1 | Receive transfer completed |
| tx_done | input | 1 | Transmit transfer completed |
| rx_size | input | 2 | Size code of the receive transfer |
| tx_size | input | 2 | Size code of the transmit transfer |
| rx_trig_en | output | 1 | Receive transfer may be started |
| tx_trig_en | output | 1 | Transmit transfer may be started |
| rx_end | output | 1 | Receive buffer ended |
| tx_end | output | 1 | Transmit buffer ended |
| rx_full | output | 1 | Both receive buffers exhausted |
| tx_empty | output | 1 | Both transmit buffers exhausted |

## Verification
On every cycle, the assertions check the following:
- the pointer step and countdown after an accepted done pulse;
- the stop and reload at the end of a buffer;
- that registers hold still when there is neither a done pulse nor a write;
- that an exhausted channel stays exhausted until it is written;
- the disable priority of the control register.

Only the bench scenarios can show the following:
- the register map and its read-back widths;
- the write-wins behaviour when a write and a done pulse coincide;
- that zero control bits leave the enables alone;
- that a late done pulse on an idle channel leaves the pointer in place.

// File: rtl/dma_pair_pkg.sv
package dma_pair_pkg;

  localparam int DIRS = 2;

  // byte step of the pointer for a given transfer size code
  function automatic logic [2:0] step_bytes(input logic [1:0] code);
    case (code)
      2'b00:   step_bytes = 3'd1;
      2'b01:   step_bytes = 3'd2;
      default: step_bytes = 3'd4;
    endcase
  endfunction

  function automatic int ofs_ptr(input int d);
    ofs_ptr = 32'h100 + 8 * d;
  endfunction

  function automatic int ofs_cnt(input int d);
    ofs_cnt = 32'h104 + 8 * d;
  endfunction

  function automatic int ofs_nptr(input int d);
    ofs_nptr = 32'h110 + 8 * d;
  endfunction

  function automatic int ofs_ncnt(input int d);
    ofs_ncnt = 32'h114 + 8 * d;
  endfunction

  localparam int OFS_CTL  = 32'h120;
  localparam int OFS_STAT = 32'h124;

  // bit position of the enable and disable control bits per direction
  function automatic int en_bit(input int d);
    en_bit = 8 * d;
  endfunction

  function automatic int dis_bit(input int d);
    dis_bit = 8 * d + 1;
  endfunction

endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pair_pkg::*;
#(
  parameter int PTR_W  = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ptr,
  input  logic              wr_cnt,
  input  logic              wr_nptr,
  input  logic              wr_ncnt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done,
  input  logic [1:0]        size,
  input  logic              en,
  input  logic              ready,
  output logic [PTR_W-1:0]  ptr,
  output logic [CNT_W-1:0]  cnt,
  output logic [PTR_W-1:0]  nptr,
  output logic [CNT_W-1:0]  ncnt,
  output logic              end_flag,
  output logic              drained,
  output logic              trig,
  output logic              done_ev,
  output logic              reload_ev
);

  logic last_ev;

  assign done_ev   = done && (cnt != '0);
  assign last_ev   = done_ev && (cnt == CNT_W'(1));
  assign reload_ev = last_ev && (ncnt != '0);
  assign drained   = (cnt == '0) && (ncnt == '0);
  assign trig      = en && ready && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      cnt      <= '0;
      nptr     <= '0;
      ncnt     <= '0;
      end_flag <= 1'b0;
    end else begin
      if (wr_ptr)         ptr <= wdata[PTR_W-1:0];
      else if (reload_ev) ptr <= nptr;
      else if (done_ev)   ptr <= ptr + PTR_W'(step_bytes(size));

      if (wr_cnt)         cnt <= wdata[CNT_W-1:0];
      else if (reload_ev) cnt <= ncnt;
      else if (done_ev)   cnt <= cnt - CNT_W'(1);

      if (wr_nptr) nptr <= wdata[PTR_W-1:0];

      if (wr_ncnt)        ncnt <= wdata[CNT_W-1:0];
      else if (reload_ev) ncnt <= '0;

      if (last_ev && !wr_cnt)    end_flag <= 1'b1;
      else if (wr_cnt || wr_ncnt) end_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_en_ctl.sv
module dma_en_ctl
  import dma_pair_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DIRS-1:0]   en
);

  for (genvar d = 0; d < DIRS; d++) begin : g_dir
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        en[d] <= 1'b0;
      else if (ctl_wr && wdata[dis_bit(d)]) en[d] <= 1'b0;
      else if (ctl_wr && wdata[en_bit(d)])  en[d] <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_reg_dec.sv
module dma_reg_dec
  import dma_pair_pkg::*;
#(
  parameter int PTR_W  = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 14
) (
  input  logic                        sel,
  input  logic                        stb,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DIRS-1:0][PTR_W-1:0]  ptr_v,
  input  logic [DIRS-1:0][CNT_W-1:0]  cnt_v,
  input  logic [DIRS-1:0][PTR_W-1:0]  nptr_v,
  input  logic [DIRS-1:0][CNT_W-1:0]  ncnt_v,
  input  logic [DIRS-1:0]             en_v,
  output logic [DIRS-1:0]             wr_ptr_v,
  output logic [DIRS-1:0]             wr_cnt_v,
  output logic [DIRS-1:0]             wr_nptr_v,
  output logic [DIRS-1:0]             wr_ncnt_v,
  output logic                        ctl_wr,
  output logic [DATA_W-1:0]           rdata
);

  logic wacc, racc;

  assign wacc   = sel && stb && wr;
  assign racc   = sel && stb && !wr;
  assign ctl_wr = wacc && (addr == ADDR_W'(OFS_CTL));

  for (genvar d = 0; d < DIRS; d++) begin : g_wr
    assign wr_ptr_v[d]  = wacc && (addr == ADDR_W'(ofs_ptr(d)));
    assign wr_cnt_v[d]  = wacc && (addr == ADDR_W'(ofs_cnt(d)));
    assign wr_nptr_v[d] = wacc && (addr == ADDR_W'(ofs_nptr(d)));
    assign wr_ncnt_v[d] = wacc && (addr == ADDR_W'(ofs_ncnt(d)));
  end

  always_comb begin
    rdata = '0;
    if (racc) begin
      for (int d = 0; d < DIRS; d++) begin
        if (addr == ADDR_W'(ofs_ptr(d)))  rdata = DATA_W'(ptr_v[d]);
        if (addr == ADDR_W'(ofs_cnt(d)))  rdata = DATA_W'(cnt_v[d]);
        if (addr == ADDR_W'(ofs_nptr(d))) rdata = DATA_W'(nptr_v[d]);
        if (addr == ADDR_W'(ofs_ncnt(d))) rdata = DATA_W'(ncnt_v[d]);
      end
      if (addr == ADDR_W'(OFS_STAT)) begin
        for (int d = 0; d < DIRS; d++) rdata[en_bit(d)] = en_v[d];
      end
    end
  end

endmodule

// File: rtl/dma_chan_pair.sv
module dma_chan_pair
  import dma_pair_pkg::*;
#(
  parameter int PTR_W  = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_stb,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_ready,
  input  logic              tx_ready,
  input  logic              rx_done,
  input  logic              tx_done,
  input  logic [1:0]        rx_size,
  input  logic [1:0]        tx_size,
  output logic              rx_trig_en,
  output logic              tx_trig_en,
  output logic              rx_end,
  output logic              tx_end,
  output logic              rx_full,
  output logic              tx_empty
);

  // index 0 = receive, index 1 = transmit
  logic [DIRS-1:0][PTR_W-1:0] ptr_v, nptr_v;
  logic [DIRS-1:0][CNT_W-1:0] cnt_v, ncnt_v;
  logic [DIRS-1:0]            wr_ptr_v, wr_cnt_v, wr_nptr_v, wr_ncnt_v;
  logic [DIRS-1:0]            chan_wr_v;
  logic [DIRS-1:0]            en_v, done_v, ready_v;
  logic [DIRS-1:0]            end_v, drained_v, trig_v;
  logic [DIRS-1:0]            done_ev_v, reload_ev_v;
  logic [DIRS-1:0][1:0]       size_v;
  logic                       ctl_wr;

  assign done_v  = {tx_done, rx_done};
  assign ready_v = {tx_ready, rx_ready};
  assign size_v  = {tx_size, rx_size};

  dma_reg_dec #(
    .PTR_W(PTR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .sel      (reg_sel),
    .stb      (reg_stb),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .ptr_v    (ptr_v),
    .cnt_v    (cnt_v),
    .nptr_v   (nptr_v),
    .ncnt_v   (ncnt_v),
    .en_v     (en_v),
    .wr_ptr_v (wr_ptr_v),
    .wr_cnt_v (wr_cnt_v),
    .wr_nptr_v(wr_nptr_v),
    .wr_ncnt_v(wr_ncnt_v),
    .ctl_wr   (ctl_wr),
    .rdata    (reg_rdata)
  );

  dma_en_ctl #(.DATA_W(DATA_W)) u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl_wr(ctl_wr),
    .wdata (reg_wdata),
    .en    (en_v)
  );

  for (genvar d = 0; d < DIRS; d++) begin : g_chan
    assign chan_wr_v[d] = wr_ptr_v[d] | wr_cnt_v[d] | wr_nptr_v[d] | wr_ncnt_v[d];

    dma_chan #(.PTR_W(PTR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ptr   (wr_ptr_v[d]),
      .wr_cnt   (wr_cnt_v[d]),
      .wr_nptr  (wr_nptr_v[d]),
      .wr_ncnt  (wr_ncnt_v[d]),
      .wdata    (reg_wdata),
      .done     (done_v[d]),
      .size     (size_v[d]),
      .en       (en_v[d]),
      .ready    (ready_v[d]),
      .ptr      (ptr_v[d]),
      .cnt      (cnt_v[d]),
      .nptr     (nptr_v[d]),
      .ncnt     (ncnt_v[d]),
      .end_flag (end_v[d]),
      .drained  (drained_v[d]),
      .trig     (trig_v[d]),
      .done_ev  (done_ev_v[d]),
      .reload_ev(reload_ev_v[d])
    );
  end

  assign rx_trig_en = trig_v[0];
  assign tx_trig_en = trig_v[1];
  assign rx_end     = end_v[0];
  assign tx_end     = end_v[1];
  assign rx_full    = drained_v[0];
  assign tx_empty   = drained_v[1];

endmodule

// File: rtl/dma_chan_pair_chk.sv
module dma_chan_pair_chk
  import dma_pair_pkg::*;
#(
  parameter int PTR_W  = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [DIRS-1:0][PTR_W-1:0] ptr_v,
  input logic [DIRS-1:0][CNT_W-1:0] cnt_v,
  input logic [DIRS-1:0][PTR_W-1:0] nptr_v,
  input logic [DIRS-1:0][CNT_W-1:0] ncnt_v,
  input logic [DIRS-1:0]            chan_wr_v,
  input logic [DIRS-1:0]            done_ev_v,
  input logic [DIRS-1:0]            reload_ev_v,
  input logic [DIRS-1:0]            end_v,
  input logic [DIRS-1:0]            drained_v,
  input logic [DIRS-1:0]            trig_v,
  input logic [DIRS-1:0]            en_v,
  input logic [DIRS-1:0][1:0]       size_v,
  input logic                       ctl_wr,
  input logic [DATA_W-1:0]          wdata
);

  for (genvar d = 0; d < DIRS; d++) begin : g_chk
    // R4: no trigger toward the sequencer on a disabled or finished channel
    p_trig_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      trig_v[d] |-> (en_v[d] && cnt_v[d] != '0));

    // R3: pointer step and countdown
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_ev_v[d] && cnt_v[d] > CNT_W'(1) && !chan_wr_v[d]) |=>
      (ptr_v[d] == $past(ptr_v[d]) + PTR_W'(step_bytes($past(size_v[d])))
       && cnt_v[d] == $past(cnt_v[d]) - CNT_W'(1)));

    // R5: final transfer with nothing queued
    p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_ev_v[d] && cnt_v[d] == CNT_W'(1) && ncnt_v[d] == '0 && !chan_wr_v[d]) |=>
      (cnt_v[d] == '0 && end_v[d]));

    // R6: hardware reload of the queued buffer
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_ev_v[d] && !chan_wr_v[d]) |=>
      (ptr_v[d] == $past(nptr_v[d]) && cnt_v[d] == $past(ncnt_v[d])
       && ncnt_v[d] == '0 && end_v[d]));

    // R12: without a done pulse or write, the channel state holds
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_ev_v[d] && !chan_wr_v[d]) |=>
      ($stable(ptr_v[d]) && $stable(cnt_v[d]) && $stable(ncnt_v[d])));

    // R11: an exhausted channel stays exhausted until written
    p_drained_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (drained_v[d] && !chan_wr_v[d]) |=> drained_v[d]);

    // R8: disable wins
    p_dis_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[dis_bit(d)]) |=> !en_v[d]);
  end

endmodule

bind dma_chan_pair dma_chan_pair_chk #(
  .PTR_W(PTR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ptr_v      (ptr_v),
  .cnt_v      (cnt_v),
  .nptr_v     (nptr_v),
  .ncnt_v     (ncnt_v),
  .chan_wr_v  (chan_wr_v),
  .done_ev_v  (done_ev_v),
  .reload_ev_v(reload_ev_v),
  .end_v      (end_v),
  .drained_v  (drained_v),
  .trig_v     (trig_v),
  .en_v       (en_v),
  .size_v     (size_v),
  .ctl_wr     (ctl_wr),
  .wdata      (reg_wdata)
);

// File: tb/dma_chan_pair_tb.sv
module dma_chan_pair_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_stb = 1'b0, reg_wr = 1'b0;
  logic [13:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_ready = 1'b0, tx_ready = 1'b0;
  logic        rx_done = 1'b0, tx_done = 1'b0;
  logic [1:0]  rx_size = '0, tx_size = '0;
  logic        rx_trig_en, tx_trig_en, rx_end, tx_end, rx_full, tx_empty;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_chan_pair u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_stb(reg_stb), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_ready(rx_ready), .tx_ready(tx_ready),
    .rx_done(rx_done), .tx_done(tx_done),
    .rx_size(rx_size), .tx_size(tx_size),
    .rx_trig_en(rx_trig_en), .tx_trig_en(tx_trig_en),
    .rx_end(rx_end), .tx_end(tx_end),
    .rx_full(rx_full), .tx_empty(tx_empty)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_ptr [2];
  logic [31:0] m_nptr[2];
  logic [15:0] m_cnt [2];
  logic [15:0] m_ncnt[2];
  bit          m_end [2];
  bit          m_en  [2];

  function automatic logic [31:0] incr_of(input logic [1:0] s);
    if (s == 2'd0) return 32'd1;
    if (s == 2'd1) return 32'd2;
    return 32'd4;
  endfunction

  function automatic logic [31:0] model_read();
    logic [31:0] v;
    int a;
    v = 0;
    a = int'(reg_addr);
    if (reg_sel && reg_stb && !reg_wr) begin
      case (a)
        'h100: v = m_ptr[0];
        'h104: v = {16'h0, m_cnt[0]};
        'h108: v = m_ptr[1];
        'h10C: v = {16'h0, m_cnt[1]};
        'h110: v = m_nptr[0];
        'h114: v = {16'h0, m_ncnt[0]};
        'h118: v = m_nptr[1];
        'h11C: v = {16'h0, m_ncnt[1]};
        'h124: v = {23'h0, m_en[1], 7'h0, m_en[0]};
        default: v = 0;
      endcase
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        m_ptr[d] = 0; m_nptr[d] = 0; m_cnt[d] = 0; m_ncnt[d] = 0;
        m_end[d] = 0; m_en[d] = 0;
      end
    end else begin
      bit w;
      w = reg_sel && reg_stb && reg_wr;
      for (int d = 0; d < 2; d++) begin
        bit dn, take, hit0, chain, wp, wc, wnp, wnc;
        logic [1:0]  sz;
        logic [31:0] np;
        logic [15:0] nc, nnc;
        dn  = (d == 0) ? rx_done : tx_done;
        sz  = (d == 0) ? rx_size : tx_size;
        wp  = w && (int'(reg_addr) == 'h100 + 8 * d);
        wc  = w && (int'(reg_addr) == 'h104 + 8 * d);
        wnp = w && (int'(reg_addr) == 'h110 + 8 * d);
        wnc = w && (int'(reg_addr) == 'h114 + 8 * d);
        take  = dn && (m_cnt[d] != 0);
        hit0  = take && (m_cnt[d] == 1);
        chain = hit0 && (m_ncnt[d] != 0);
        np = m_ptr[d]; nc = m_cnt[d]; nnc = m_ncnt[d];
        if (chain) begin np = m_nptr[d]; nc = m_ncnt[d]; nnc = 0; end
        else if (take) begin np = m_ptr[d] + incr_of(sz); nc = m_cnt[d] - 1; end
        if (wp)  np = reg_wdata;
        if (wc)  nc = reg_wdata[15:0];
        if (wnc) nnc = reg_wdata[15:0];
        if (wc || wnc) m_end[d] = 0;
        if (hit0 && !wc) m_end[d] = 1;
        if (wnp) m_nptr[d] = reg_wdata;
        m_ptr[d] = np; m_cnt[d] = nc; m_ncnt[d] = nnc;
      end
      if (w && int'(reg_addr) == 'h120) begin
        for (int d = 0; d < 2; d++) begin
          if (reg_wdata[8 * d]) m_en[d] = 1;
          if (reg_wdata[8 * d + 1]) m_en[d] = 0;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      bit rdy0, rdy1;
      rdy0 = rx_ready; rdy1 = tx_ready;
      check("R4 rx_trig_en", 32'(rx_trig_en), 32'(m_en[0] && rdy0 && m_cnt[0] != 0));
      check("R4 tx_trig_en", 32'(tx_trig_en), 32'(m_en[1] && rdy1 && m_cnt[1] != 0));
      check("R5 rx_end", 32'(rx_end), 32'(m_end[0]));
      check("R5 tx_end", 32'(tx_end), 32'(m_end[1]));
      check("R11 rx_full", 32'(rx_full), 32'(m_cnt[0] == 0 && m_ncnt[0] == 0));
      check("R11 tx_empty", 32'(tx_empty), 32'(m_cnt[1] == 0 && m_ncnt[1] == 0));
      check("R2 reg_rdata", reg_rdata, model_read());
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic bus_idle();
    reg_sel = 0; reg_stb = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    @(negedge clk);
    reg_sel = 1; reg_stb = 1; reg_wr = 1; reg_addr = 14'(a); reg_wdata = v;
    @(negedge clk);
    bus_idle();
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_sel = 1; reg_stb = 1; reg_wr = 0; reg_addr = 14'(a);
    #3;
    check(tag, reg_rdata, exp);
    @(negedge clk);
    bus_idle();
  endtask

  task automatic pulse(input int d, input logic [1:0] sz);
    @(negedge clk);
    if (d == 0) begin rx_done = 1; rx_size = sz; end
    else begin tx_done = 1; tx_size = sz; end
    @(negedge clk);
    rx_done = 0; tx_done = 0;
  endtask

  task automatic wr_and_pulse(input int a, input logic [31:0] v, input int d, input logic [1:0] sz);
    @(negedge clk);
    reg_sel = 1; reg_stb = 1; reg_wr = 1; reg_addr = 14'(a); reg_wdata = v;
    if (d == 0) begin rx_done = 1; rx_size = sz; end
    else begin tx_done = 1; tx_size = sz; end
    @(negedge clk);
    bus_idle();
    rx_done = 0; tx_done = 0;
  endtask

  task automatic flag(input string tag, input logic act, input logic exp);
    #1;
    check(tag, 32'(act), 32'(exp));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- directed scenarios ----------------
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int a = 'h100; a <= 'h124; a += 4) rd(a, 32'h0, "R1 reset read");
    flag("R1 rx_full after reset", rx_full, 1'b1);
    flag("R1 tx_empty after reset", tx_empty, 1'b1);
    flag("R1 rx_end after reset", rx_end, 1'b0);

    // R3 R4 R5: single receive buffer of three transfers
    rx_ready = 1;
    wr('h100, 32'h0000_1000);
    wr('h104, 32'd3);
    flag("R4 disabled no trigger", rx_trig_en, 1'b0);
    wr('h120, 32'h0000_0001);
    rd('h124, 32'h0000_0001, "R9 status rx enabled");
    flag("R4 rx trigger on", rx_trig_en, 1'b1);
    pulse(0, 2'b00);
    pulse(0, 2'b01);
    rd('h100, 32'h0000_1003, "R3 rx pointer after byte+half");
    rd('h104, 32'd1, "R3 rx counter after two transfers");
    pulse(0, 2'b10);
    rd('h100, 32'h0000_1007, "R3 rx pointer after word");
    flag("R5 rx_end set", rx_end, 1'b1);
    flag("R5 rx trigger removed", rx_trig_en, 1'b0);
    flag("R11 rx_full when both zero", rx_full, 1'b1);

    // R7 R11: counter write clears end and full
    wr('h104, 32'd2);
    flag("R7 rx_end cleared by counter write", rx_end, 1'b0);
    flag("R11 rx_full cleared", rx_full, 1'b0);

    // R6: chained transmit buffers
    tx_ready = 1;
    wr('h108, 32'h0000_2000);
    wr('h10C, 32'd1);
    wr('h118, 32'h0000_3000);
    wr('h11C, 32'd2);
    wr('h120, 32'h0000_0100);
    flag("R4 tx trigger on", tx_trig_en, 1'b1);
    pulse(1, 2'b11);
    flag("R6 tx_end on reload", tx_end, 1'b1);
    flag("R6 tx trigger resumes", tx_trig_en, 1'b1);
    rd('h108, 32'h0000_3000, "R6 pointer reloaded");
    rd('h10C, 32'd2, "R6 counter reloaded");
    rd('h11C, 32'd0, "R6 next counter cleared");
    pulse(1, 2'b11);
    pulse(1, 2'b11);
    rd('h108, 32'h0000_3008, "R3 size code 11 steps by 4");
    flag("R11 tx_empty after second buffer", tx_empty, 1'b1);
    wr('h11C, 32'd0);
    flag("R7 tx_end cleared by next counter write", tx_end, 1'b0);

    // R12: done on an empty channel is ignored
    pulse(1, 2'b00);
    rd('h108, 32'h0000_3008, "R12 pointer unchanged");
    flag("R12 tx_end stays low", tx_end, 1'b0);

    // R10: write and done in the same cycle
    wr_and_pulse('h104, 32'd9, 0, 2'b00);
    rd('h104, 32'd9, "R10 counter write wins");
    rd('h100, 32'h0000_1008, "R10 pointer still steps");
    wr_and_pulse('h100, 32'h0000_4000, 0, 2'b01);
    rd('h100, 32'h0000_4000, "R10 pointer write wins");
    rd('h104, 32'd8, "R10 counter still counts");

    // R8 R9: control register
    wr('h108, 32'h0000_5000);
    wr('h10C, 32'd4);
    rd('h124, 32'h0000_0101, "R9 both enabled");
    wr('h120, 32'h0);
    rd('h124, 32'h0000_0101, "R8 zero bits no effect");
    wr('h120, 32'h0000_0202);
    rd('h124, 32'h0, "R8 both disabled");
    flag("R4 rx trigger off when disabled", rx_trig_en, 1'b0);
    wr('h120, 32'h0000_0303);
    rd('h124, 32'h0, "R8 disable wins over enable");
    wr('h120, 32'h0000_0001);
    rd('h124, 32'h0000_0001, "R9 rx only");

    // R2: map details
    wr('h124, 32'hFFFF_FFFF);
    rd('h124, 32'h0000_0001, "R2 status not writable");
    rd('h120, 32'h0, "R2 control reads zero");
    wr('h114, 32'hABCD_1234);
    rd('h114, 32'h0000_1234, "R2 counter keeps low 16 bits");
    rd('h130, 32'h0, "R2 unmapped reads zero");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule